// File: doc/BRIEF.md
# Sequential Single-Precision Divider

This block divides one normalized 32-bit single-precision value by another over a fixed number of clock cycles. A one-cycle `start` pulse captures both operands. The block then finds the significand quotient with a restoring shift-and-subtract loop that yields one quotient bit per clock. It normalizes and packs the result and raises `done` for exactly one cycle. The result sign is the exclusive-or of the operand signs. The exponent is the difference of the two biased exponents with the bias of 127 added back.

The significand is truncated, with no rounding. Results whose biased exponent lands outside 1..254 are clamped and flagged. A divisor whose magnitude bits are all zero gives signed infinity. Subnormal operands, and a zero dividend, are outside the block's contract. The host waits for `done` and reads `quotient`, `ovf` and `unf`. These outputs hold their values until the next operation finishes.

Top module: `fp_seq_divider`

## Requirements
- R1: The sign bit of the result (bit 31) equals the exclusive-or of bit 31 of the dividend and bit 31 of the divisor, in every case including the flagged ones.
- R2: The unclamped biased exponent is the dividend exponent field (bits 30:23) minus the divisor exponent field plus 127. It is reduced by one more when the dividend significand is smaller than the divisor significand, and it is placed in bits 30:23 of the result.
- R3: The result fraction (bits 22:0) is the exact significand quotient 1.fa / 1.fb, normalized into [1,2) and truncated to 23 fraction bits.
- R4: When the exponent from R2 exceeds 254 the result is signed infinity (exponent field 0xFF, fraction 0), with `ovf` set and `unf` clear.
- R5: When the exponent from R2 is below 1 the result is signed zero (bits 30:0 all zero), with `unf` set and `ovf` clear.
- R6: A divisor whose bits 30:0 are all zero gives signed infinity with `ovf` set, whatever the dividend is.
- R7: If `start` is seen high at a clock edge while the block is idle, `busy` rises after that edge and stays high for 26 cycles. On the 26th following edge `busy` falls and `done` rises for exactly one cycle.
- R8: A `start` pulse while `busy` is high is ignored. The running operation completes on time with the operands captured at its own start.
- R9: After reset `busy`, `done`, `ovf`, `unf` and `quotient` are all zero.
- R10: `quotient`, `ovf` and `unf` change only in the cycle where `done` is high, and hold between operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division when idle |
| dividend | input | 32 | Numerator, single-precision |
| divisor | input | 32 | Denominator, single-precision |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Packed result |
| ovf | output | 1 | Exponent overflow or zero divisor |
| unf | output | 1 | Exponent underflow |

## Verification
The bench runs its own timing model alongside the design. A fault in the iteration counter or in the busy logic moves `done` by a cycle, and that shows on the first operation. A fault in the remainder or in the divisor shift changes only the quotient bits below the faulty step, so it shows in the low fraction bits when `done` first pulses. Operand pairs whose significand ratio falls just above and just below one exercise both normalization paths. An exponent error is caught at the 254/255 and 1/0 limits, where it flips the `ovf` or `unf` flag.

// File: rtl/fp_seq_divider.sv
module fp_seq_divider (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] dividend,
  input  logic [31:0] divisor,
  output logic        busy,
  output logic        done,
  output logic [31:0] quotient,
  output logic        ovf,
  output logic        unf
);
  localparam int SW    = 24;
  localparam int RW    = 2 * SW;
  localparam int QW    = SW + 1;
  localparam int CW    = $clog2(QW + 1);
  localparam logic [CW-1:0] LAST = CW'(QW);

  logic [RW-1:0]       rem, dvs;
  logic [QW-1:0]       q;
  logic [CW-1:0]       cnt;
  logic                sgn, zdiv;
  logic signed [9:0]   exr;

  logic [RW:0]         trial;
  logic                ge;
  logic                lead;
  logic signed [9:0]   e_fin;
  logic [22:0]         frac;
  logic                too_big, too_small;
  logic [31:0]         packed_q;

  assign trial = {1'b0, rem} - {1'b0, dvs};
  assign ge    = ~trial[RW];

  assign lead      = q[QW-1];
  assign e_fin     = exr - (lead ? 10'sd0 : 10'sd1);
  assign frac      = lead ? q[23:1] : q[22:0];
  assign too_big   = zdiv | (e_fin > 10'sd254);
  assign too_small = ~zdiv & (e_fin < 10'sd1);
  assign packed_q  = too_big   ? {sgn, 8'hFF, 23'h0} :
                     too_small ? {sgn, 31'h0} :
                                 {sgn, e_fin[7:0], frac};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      quotient <= '0;
      ovf      <= 1'b0;
      unf      <= 1'b0;
      rem      <= '0;
      dvs      <= '0;
      q        <= '0;
      cnt      <= '0;
      sgn      <= 1'b0;
      zdiv     <= 1'b0;
      exr      <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
          q    <= '0;
          rem  <= {1'b1, dividend[22:0], {SW{1'b0}}};
          dvs  <= {1'b1, divisor[22:0], {SW{1'b0}}};
          sgn  <= dividend[31] ^ divisor[31];
          zdiv <= (divisor[30:0] == 31'h0);
          exr  <= $signed({2'b00, dividend[30:23]}) - $signed({2'b00, divisor[30:23]}) + 10'sd127;
        end
      end else if (cnt == LAST) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        quotient <= packed_q;
        ovf      <= too_big;
        unf      <= too_small;
      end else begin
        if (ge) rem <= trial[RW-1:0];
        q   <= {q[QW-2:0], ge};
        dvs <= dvs >> 1;
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fp_seq_divider_chk.sv
module fp_seq_divider_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [31:0] quotient,
  input logic        ovf,
  input logic        unf
);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_ends_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_no_overflow_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> (quotient[30:23] == 8'hFF && quotient[22:0] == 23'h0));

  assert_underflow_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && unf) |-> (quotient[30:0] == 31'h0));

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));

  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(ovf) && $stable(unf)));
endmodule

bind fp_seq_divider fp_seq_divider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .quotient(quotient), .ovf(ovf), .unf(unf)
);

// File: tb/fp_seq_divider_test.sv
module fp_seq_divider_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] dividend = '0, divisor = '0;
  logic busy, done, ovf, unf;
  logic [31:0] quotient;

  int checks = 0, fails = 0, cycles = 0;

  fp_seq_divider uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .ovf(ovf), .unf(unf)
  );

  always #2.5 clk = ~clk;

  // expected {ovf, unf, result}
  function automatic logic [33:0] ref_div(input logic [31:0] x, input logic [31:0] y);
    logic s;
    longint ma, mb, qq;
    int e;
    logic [22:0] f;
    s = x[31] ^ y[31];
    if (y[30:0] == 31'h0) return {1'b1, 1'b0, s, 8'hFF, 23'h0};
    ma = longint'({1'b1, x[22:0]});
    mb = longint'({1'b1, y[22:0]});
    qq = (ma <<< 24) / mb;
    e  = int'(x[30:23]) - int'(y[30:23]) + 127;
    if (qq >= (64'sd1 <<< 24)) f = 23'((qq >>> 1) & 64'h7FFFFF);
    else begin e = e - 1; f = 23'(qq & 64'h7FFFFF); end
    if (e > 254) return {1'b1, 1'b0, s, 8'hFF, 23'h0};
    if (e < 1)   return {1'b0, 1'b1, s, 31'h0};
    return {2'b00, s, 8'(e), f};
  endfunction

  // behavioural timing model
  logic m_busy = 1'b0, m_done = 1'b0, m_ovf = 1'b0, m_unf = 1'b0;
  logic [31:0] m_q = '0;
  int m_cnt = 0;
  logic [33:0] pend[$];
  string m_tag = "R3";

  always @(posedge clk) begin
    logic [33:0] r;
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_ovf <= 1'b0; m_unf <= 1'b0; m_q <= '0; m_cnt <= 0;
      pend.delete();
    end else begin
      m_done <= 1'b0;
      if (!m_busy) begin
        if (start) begin
          m_busy <= 1'b1; m_cnt <= 0;
          pend.push_back(ref_div(dividend, divisor));
          m_tag <= (divisor[30:0] == 31'h0) ? "R6" : "R3";
        end
      end else if (m_cnt == 25) begin
        r = pend.pop_front();
        m_busy <= 1'b0; m_done <= 1'b1;
        m_ovf <= r[33]; m_unf <= r[32]; m_q <= r[31:0];
      end else m_cnt <= m_cnt + 1;
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R7", "busy", 32'(busy), 32'(m_busy));
      check("R7", "done", 32'(done), 32'(m_done));
      if (!m_done) begin
        check("R10", "held quotient", quotient, m_q);
        check("R10", "held flags", {30'h0, ovf, unf}, {30'h0, m_ovf, m_unf});
      end else begin
        check("R1", "sign", 32'(quotient[31]), 32'(m_q[31]));
        check("R2", "exponent", 32'(quotient[30:23]), 32'(m_q[30:23]));
        check(m_tag, "fraction", 32'(quotient[22:0]), 32'(m_q[22:0]));
        check(m_ovf ? "R4" : m_tag, "ovf", 32'(ovf), 32'(m_ovf));
        check("R5", "unf", 32'(unf), 32'(m_unf));
      end
    end
  end

  task automatic run_op(input logic [31:0] x, input logic [31:0] y, input bit poke);
    @(negedge clk);
    start = 1'b1; dividend = x; divisor = y;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      // R8: a second start while busy must be ignored
      start = 1'b1; dividend = 32'h3F800000; divisor = 32'h40400000;
      @(negedge clk);
      start = 1'b0; dividend = '0; divisor = '0;
    end
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    check("R8", "completed", 32'(done), 32'd1);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cycles > 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "reset state", {27'h0, busy, done, ovf, unf, |quotient}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "idle after reset", {30'h0, busy, done}, 32'h0);

    run_op(32'h3F800000, 32'h3F800000, 0); // 1/1
    run_op(32'h40400000, 32'h40000000, 0); // 3/2
    run_op(32'h3F800000, 32'h40400000, 0); // 1/3 (lead bit 0)
    run_op(32'hC0C00000, 32'h40000000, 0); // -6/2 (R1)
    run_op(32'h40F00000, 32'hBDCCCCCD, 0); // 7.5 / -0.1
    run_op(32'hC1200000, 32'hC0E00000, 0); // both negative
    run_op(32'h7F7FFFFF, 32'h3F800000, 0); // exponent exactly 254
    run_op(32'h7F000000, 32'h3F000000, 0); // 255 -> R4
    run_op(32'h7F000000, 32'h00800000, 0); // large overflow R4
    run_op(32'h00800000, 32'h3F800000, 0); // exponent exactly 1
    run_op(32'h00800000, 32'h3FC00000, 0); // 0 -> R5
    run_op(32'h80800000, 32'h7F000000, 0); // deep underflow, negative
    run_op(32'h40490FDB, 32'h00000000, 0); // R6 zero divisor
    run_op(32'h40490FDB, 32'h80000000, 0); // R6 negative zero divisor
    run_op(32'h41200000, 32'h40A00000, 1); // R8 start while busy

    for (int k = 0; k < 40; k++) begin
      logic [31:0] x, y;
      x = {1'($urandom), 8'(1 + $urandom_range(0, 253)), 23'($urandom)};
      y = {1'($urandom), 8'(1 + $urandom_range(0, 253)), 23'($urandom)};
      run_op(x, y, 0);
    end

    // back-to-back: start in the cycle right after done
    @(negedge clk);
    start = 1'b1; dividend = 32'h40000000; divisor = 32'h3F000000;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    start = 1'b1; dividend = 32'h3F000000; divisor = 32'h40000000;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    check("R7", "back-to-back done", 32'(done), 32'd1);
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule